// File: doc/BRIEF.md
# Pipeline Hazard and Fetch Address Control

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it picks the address to fetch from. It also drives the stall and bubble controls of the fetch, decode and execute pipeline registers. It reads the opcode held at each stage, the condition outcome latched for the instruction in memory, the fall-through address carried by that instruction, the loaded word in writeback, and the register numbers that reveal a load feeding the next instruction.

The block assumes every jump is taken. It keeps the guessed next address in its own fetch-side register. A wrong guess is repaired once the jump reaches memory: only decode and execute are squashed, and fetch restarts at the fall-through address. A return blocks fetch while it moves from decode to memory. Its target is then taken from the value loaded in writeback. A load whose result feeds the next instruction holds the front of the pipeline for one cycle. The datapath, register file, memory and forwarding are outside this block.

Top module: `pipe_ctl`

## Requirements
- R1: While reset is low and right after reset, with no hazard at the inputs, pc_o equals RESET_PC (default 0) and all stall and bubble outputs are 0.
- R2: On a clock edge where fetch is not stalled, the stored guess becomes f_valc_i if f_op_i is a jump (4'h7) or call (4'h8), and f_valp_i for any other opcode (no-op is 4'h1, ALU op is 4'h6).
- R3: With no hazard, pc_o equals the stored guess and all stall and bubble outputs are 0.
- R4: A misprediction is when m_op_i is a jump (4'h7) and m_cnd_i is 0. In that case pc_o equals m_valp_i, bubble_d_o and bubble_e_o are 1, and stall_f_o and stall_d_o are 0.
- R5: A jump in memory with m_cnd_i at 1 changes neither pc_o nor any control output.
- R6: While a return (4'h9) is in decode, execute or memory, stall_f_o and bubble_d_o are 1. The stored guess is held, even when the fetch inputs change.
- R7: When a return is in writeback and there is no misprediction, pc_o equals w_valm_i.
- R8: A load-use hazard is when e_op_i is a memory load (4'h5) or a pop (4'hB) and e_dst_m_i equals d_src_a_i or d_src_b_i. It sets stall_f_o, stall_d_o and bubble_e_o to 1 and bubble_d_o to 0. Other opcodes in execute never cause it.
- R9: A misprediction takes priority over a return stall, a return in writeback and a load-use hazard. The outputs are then exactly as in R4.
- R10: A load-use hazard with a return in decode gives stall_d_o at 1 and bubble_d_o at 0.
- R11: Register number 4'hF means "none". A destination of 4'hF never raises a load-use hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| f_op_i | input | 4 | Opcode of the instruction being fetched |
| f_valc_i | input | ADDR_W | Immediate target of the fetched instruction |
| f_valp_i | input | ADDR_W | Fall-through address of the fetched instruction |
| d_op_i | input | 4 | Opcode in decode register |
| e_op_i | input | 4 | Opcode in execute register |
| m_op_i | input | 4 | Opcode in memory register |
| w_op_i | input | 4 | Opcode in writeback register |
| m_cnd_i | input | 1 | Latched condition result in memory register |
| m_valp_i | input | ADDR_W | Fall-through address in memory register |
| w_valm_i | input | ADDR_W | Loaded value in writeback register |
| e_dst_m_i | input | REG_W | Load destination in execute |
| d_src_a_i | input | REG_W | First source register in decode |
| d_src_b_i | input | REG_W | Second source register in decode |
| pc_o | output | ADDR_W | Fetch address |
| stall_f_o | output | 1 | Hold fetch register |
| stall_d_o | output | 1 | Hold decode register |
| bubble_d_o | output | 1 | Load no-op into decode register |
| bubble_e_o | output | 1 | Load no-op into execute register |

## Verification
Three pairs of functions can fall in the same cycle:
- a misprediction together with a return in execute,
- a misprediction together with a load-use hazard,
- a load-use hazard together with a return waiting in decode.

Each pair is provoked by one vector that presents both stage opcodes at once. The check is the full set of control outputs plus the selected fetch address: the misprediction must win outright, and in the last pair the decode hold must beat the decode bubble.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_CMOV  = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import pipe_ctl_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [OP_W-1:0]  d_op_i,
  input  logic [OP_W-1:0]  e_op_i,
  input  logic [OP_W-1:0]  m_op_i,
  input  logic [OP_W-1:0]  w_op_i,
  input  logic             m_cnd_i,
  input  logic [REG_W-1:0] e_dst_m_i,
  input  logic [REG_W-1:0] d_src_a_i,
  input  logic [REG_W-1:0] d_src_b_i,
  output logic             mispredict_o,
  output logic             ret_busy_o,
  output logic             ret_wb_o,
  output logic             load_use_o
);
  localparam int NSRC = 2;
  localparam logic [REG_W-1:0] REG_NONE = '1;

  logic [REG_W-1:0] src [NSRC];
  logic [NSRC-1:0]  hit;
  logic             e_is_load;

  assign src[0] = d_src_a_i;
  assign src[1] = d_src_b_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = (src[g] == e_dst_m_i);
  end

  assign e_is_load    = (e_op_i == OP_MRMOV) || (e_op_i == OP_POP);
  assign load_use_o   = e_is_load && (e_dst_m_i != REG_NONE) && (|hit);
  assign mispredict_o = (m_op_i == OP_JUMP) && !m_cnd_i;
  assign ret_busy_o   = (d_op_i == OP_RET) || (e_op_i == OP_RET) || (m_op_i == OP_RET);
  assign ret_wb_o     = (w_op_i == OP_RET);
endmodule

// File: rtl/stage_ctl.sv
module stage_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mispredict_i,
  input  logic ret_busy_i,
  input  logic load_use_i,
  output logic stall_f_o,
  output logic stall_d_o,
  output logic bubble_d_o,
  output logic bubble_e_o
);
  // mispredict squashes any return or load sitting in decode/execute
  assign stall_f_o  = !mispredict_i && (ret_busy_i || load_use_i);
  assign stall_d_o  = !mispredict_i && load_use_i;
  assign bubble_d_o = mispredict_i || (ret_busy_i && !load_use_i);
  assign bubble_e_o = mispredict_i || load_use_i;

  p_no_hold_on_redirect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |-> (!stall_f_o && !stall_d_o && bubble_d_o && bubble_e_o));

  p_hold_beats_bubble_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_d_o && bubble_d_o));

  p_load_freeze_front_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bubble_e_o && !mispredict_i) |-> (stall_f_o && stall_d_o));

  p_ret_blocks_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_busy_i && !mispredict_i) |-> stall_f_o);
endmodule

// File: rtl/pc_select.sv
module pc_select
  import pipe_ctl_pkg::*;
#(
  parameter int              ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_f_i,
  input  logic              mispredict_i,
  input  logic              ret_wb_i,
  input  logic [OP_W-1:0]   f_op_i,
  input  logic [ADDR_W-1:0] f_valc_i,
  input  logic [ADDR_W-1:0] f_valp_i,
  input  logic [ADDR_W-1:0] m_valp_i,
  input  logic [ADDR_W-1:0] w_valm_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pred_q, pred_d;
  logic              take_target;

  assign take_target = (f_op_i == OP_JUMP) || (f_op_i == OP_CALL);
  assign pred_d      = take_target ? f_valc_i : f_valp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pred_q <= RESET_PC;
    else if (!stall_f_i) pred_q <= pred_d;
  end

  always_comb begin
    if (mispredict_i)  pc_o = m_valp_i;
    else if (ret_wb_i) pc_o = w_valm_i;
    else               pc_o = pred_q;
  end

  p_hold_guess_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_f_i |=> $stable(pred_q));

  p_redirect_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |-> (pc_o == m_valp_i));

  p_ret_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_wb_i && !mispredict_i) |-> (pc_o == w_valm_i));
endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_ctl_pkg::*;
#(
  parameter int                ADDR_W   = 64,
  parameter int                REG_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        f_op_i,
  input  logic [ADDR_W-1:0] f_valc_i,
  input  logic [ADDR_W-1:0] f_valp_i,
  input  logic [3:0]        d_op_i,
  input  logic [3:0]        e_op_i,
  input  logic [3:0]        m_op_i,
  input  logic [3:0]        w_op_i,
  input  logic              m_cnd_i,
  input  logic [ADDR_W-1:0] m_valp_i,
  input  logic [ADDR_W-1:0] w_valm_i,
  input  logic [REG_W-1:0]  e_dst_m_i,
  input  logic [REG_W-1:0]  d_src_a_i,
  input  logic [REG_W-1:0]  d_src_b_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              stall_f_o,
  output logic              stall_d_o,
  output logic              bubble_d_o,
  output logic              bubble_e_o
);
  logic mispredict, ret_busy, ret_wb, load_use;

  hazard_detect #(.REG_W(REG_W)) u_haz (
    .d_op_i       (d_op_i),
    .e_op_i       (e_op_i),
    .m_op_i       (m_op_i),
    .w_op_i       (w_op_i),
    .m_cnd_i      (m_cnd_i),
    .e_dst_m_i    (e_dst_m_i),
    .d_src_a_i    (d_src_a_i),
    .d_src_b_i    (d_src_b_i),
    .mispredict_o (mispredict),
    .ret_busy_o   (ret_busy),
    .ret_wb_o     (ret_wb),
    .load_use_o   (load_use)
  );

  stage_ctl u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mispredict_i (mispredict),
    .ret_busy_i   (ret_busy),
    .load_use_i   (load_use),
    .stall_f_o    (stall_f_o),
    .stall_d_o    (stall_d_o),
    .bubble_d_o   (bubble_d_o),
    .bubble_e_o   (bubble_e_o)
  );

  pc_select #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_f_i    (stall_f_o),
    .mispredict_i (mispredict),
    .ret_wb_i     (ret_wb),
    .f_op_i       (f_op_i),
    .f_valc_i     (f_valc_i),
    .f_valp_i     (f_valp_i),
    .m_valp_i     (m_valp_i),
    .w_valm_i     (w_valm_i),
    .pc_o         (pc_o)
  );
endmodule

// File: tb/sim_pipe_ctl.sv
`timescale 1ns/1ps
module sim_pipe_ctl;
  localparam int AW = 64;
  localparam logic [AW-1:0] GUESS = 64'h40;
  localparam logic [AW-1:0] FALLT = 64'h100;
  localparam logic [AW-1:0] LOADV = 64'h200;

  logic          clk = 0, rst_n = 0;
  logic [3:0]    f_op = 4'h1, d_op = 4'h1, e_op = 4'h1, m_op = 4'h1, w_op = 4'h1;
  logic [AW-1:0] f_valc = '0, f_valp = GUESS;
  logic          m_cnd = 1'b1;
  logic [3:0]    e_dst = 4'hF, src_a = 4'hF, src_b = 4'hF;
  logic [AW-1:0] pc;
  logic          sf, sd, bd, be;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  pipe_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .f_op_i(f_op), .f_valc_i(f_valc), .f_valp_i(f_valp),
    .d_op_i(d_op), .e_op_i(e_op), .m_op_i(m_op), .w_op_i(w_op), .m_cnd_i(m_cnd),
    .m_valp_i(FALLT), .w_valm_i(LOADV), .e_dst_m_i(e_dst), .d_src_a_i(src_a),
    .d_src_b_i(src_b), .pc_o(pc), .stall_f_o(sf), .stall_d_o(sd),
    .bubble_d_o(bd), .bubble_e_o(be)
  );

  // {d,e,m,w,cnd,e_dst,src_a,src_b, sf,sd,bd,be, pc_sel(0 guess,1 fallthrough,2 loaded)}
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {4'h1,4'h1,4'h1,4'h1,1'b1,4'hF,4'hF,4'hF,4'b0000,2'd0}, // R3 idle
    {4'h1,4'h1,4'h7,4'h1,1'b1,4'hF,4'hF,4'hF,4'b0000,2'd0}, // R5 taken jump ok
    {4'h1,4'h1,4'h7,4'h1,1'b0,4'hF,4'hF,4'hF,4'b0011,2'd1}, // R4 mispredict
    {4'h9,4'h1,4'h1,4'h1,1'b1,4'hF,4'hF,4'hF,4'b1010,2'd0}, // R6 ret in D
    {4'h1,4'h9,4'h1,4'h1,1'b1,4'hF,4'hF,4'hF,4'b1010,2'd0}, // R6 ret in E
    {4'h1,4'h1,4'h9,4'h1,1'b1,4'hF,4'hF,4'hF,4'b1010,2'd0}, // R6 ret in M
    {4'h1,4'h1,4'h1,4'h9,1'b1,4'hF,4'hF,4'hF,4'b0000,2'd2}, // R7 ret in W
    {4'h6,4'h5,4'h1,4'h1,1'b1,4'h3,4'h3,4'hF,4'b1101,2'd0}, // R8 load->srcA
    {4'h6,4'hB,4'h1,4'h1,1'b1,4'h2,4'hF,4'h2,4'b1101,2'd0}, // R8 pop->srcB
    {4'h6,4'h5,4'h1,4'h1,1'b1,4'h3,4'h4,4'h5,4'b0000,2'd0}, // R8 no match
    {4'h6,4'h5,4'h1,4'h1,1'b1,4'hF,4'hF,4'hF,4'b0000,2'd0}, // R11 none
    {4'h1,4'h9,4'h7,4'h1,1'b0,4'hF,4'hF,4'hF,4'b0011,2'd1}, // R9 vs ret
    {4'h6,4'h5,4'h7,4'h1,1'b0,4'h3,4'h3,4'hF,4'b0011,2'd1}, // R9 vs load-use
    {4'h9,4'hB,4'h1,4'h1,1'b1,4'h4,4'h4,4'hF,4'b1101,2'd0}, // R10
    {4'h1,4'h1,4'h7,4'h9,1'b0,4'hF,4'hF,4'hF,4'b0011,2'd1}, // R9 vs ret in W
    {4'h6,4'h6,4'h1,4'h1,1'b1,4'h3,4'h3,4'h3,4'b0000,2'd0}  // R8 ALU op no stall
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input string req, input logic [3:0] exp);
    check(req, {60'd0, sf, sd, bd, be}, {60'd0, exp});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset
    #12;
    check("R1 pc in reset", pc, '0);
    ctl("R1 ctl in reset", 4'b0000);
    @(negedge clk); rst_n = 1;
    #1 check("R1 pc after reset", pc, '0);

    // R2 guess update
    @(negedge clk); f_op = 4'h7; f_valc = 64'h300; f_valp = 64'h50;
    @(negedge clk); #1 check("R2 jump takes target", pc, 64'h300);
    f_op = 4'h8; f_valc = 64'h380;
    @(negedge clk); #1 check("R2 call takes target", pc, 64'h380);
    f_op = 4'h6; f_valp = 64'h48;
    @(negedge clk); #1 check("R2 alu takes fallthrough", pc, 64'h48);

    // R6 guess held under return stall
    d_op = 4'h9; f_op = 4'h7; f_valc = 64'h999;
    @(negedge clk); #1 check("R6 guess held", pc, 64'h48);
    d_op = 4'h1; f_op = 4'h1; f_valp = GUESS;
    @(negedge clk); #1 check("R3 guess resumes", pc, GUESS);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      logic [AW-1:0] exp_pc;
      v = VEC[i];
      @(negedge clk);
      {d_op, e_op, m_op, w_op, m_cnd, e_dst, src_a, src_b} = v[34:6];
      #1;
      exp_pc = (v[1:0] == 2'd1) ? FALLT : (v[1:0] == 2'd2) ? LOADV : GUESS;
      ctl($sformatf("R3-table vec%0d ctl", i), v[5:2]);
      check($sformatf("R3-table vec%0d pc", i), pc, exp_pc);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule